// File: doc/BRIEF.md
# Vector Block Sub-Program Counter CSR Controller

This block holds the control and status register that records how far a core has progressed through a vector block, which is a prefixed group of scalar instructions. The register packs two things together. The first is the state of the block decoder, taken from the sequencer. The second is the header fields latched by that decoder. The low five bits hold the pointer to the next opcode, counted in halfwords from the start of the block's opcode area. The block also keeps one saved copy of the register for traps, standing in for the per-privilege copies.

Software reads either register, selected by `csr_sel`. A read returns the whole 32-bit word. A write to the live register is a jump inside the block. It is legal only once the predicate and register tables are loaded, and only if the new pointer lies inside the opcode area. An illegal write raises a one-cycle illegal flag and changes nothing. Writes to the saved copy are never checked. A trap strobe copies the live word into the saved copy. A return strobe loads it back with the status lowered from "tables loaded" to "VL done", so the tables are read again, and the pointer is kept.

Top module: `subpc_csr_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both the live and the saved word read as zero, and `jump_vld` and `illegal` are low.
- R2: A read returns all 32 bits. The layout is status[31:30], vlset[29], length code[28:26], pplen[25:24], rplen[23:22], mode[21], second header word[20:5] and opcode pointer[4:0]. `csr_sel`=0 selects the live word and 1 selects the saved word.
- R3: `csr_op`=10 is an immediate write. If the live status is 11 and the zero-extended `csr_imm` is below `op_len_hw`, bits [4:0] of the live word take `csr_imm` and all other bits are kept. In the next cycle `jump_vld` pulses for one cycle with `jump_ptr` equal to the new pointer.
- R4: A write to the live word while the status is not 11 pulses `illegal` in the next cycle. The live word is unchanged and no jump is raised.
- R5: A write to the live word whose pointer value is greater than or equal to `op_len_hw` pulses `illegal`. The live word is unchanged and no jump is raised.
- R6: `csr_op`=11 is a register write. It follows R3 to R5, except that the whole 32-bit `csr_wdata` is the pointer value in the range check. A value with any bit above bit 4 set is therefore out of range whenever `op_len_hw` is at most 32.
- R7: Writes to the saved word are never illegal and never jump. A register write replaces the whole saved word, and an immediate write replaces only its bits [4:0].
- R8: On `trap_i`, the saved word takes the live word at that edge, and the live word is unchanged.
- R9: On `ret_i` without `trap_i`, the live word takes the saved word, with a status of 11 replaced by 10 and any other status kept. In the next cycle `jump_vld` pulses with `jump_ptr` equal to the restored pointer.
- R10: A trap in the same cycle as a CSR write or a return cancels both. There is no jump and no illegal flag, and the saved word takes the live word as it was before that cycle.
- R11: `seq_upd` loads all live fields from the `seq_*` inputs. It is ignored in a cycle that also carries a trap, a return or a write to the live word. A read in the same cycle does not block it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_upd | input | 1 | Sequencer load strobe for the live fields |
| seq_status | input | 2 | Decoder status (00 scalar, 01 header, 10 VL done, 11 tables loaded) |
| seq_vlset | input | 1 | VL block present flag |
| seq_ilen | input | 3 | Block length code |
| seq_pplen | input | 2 | Predicate entry count code |
| seq_rplen | input | 2 | Register entry count code |
| seq_mode | input | 1 | Register entry format flag |
| seq_hdr2 | input | 16 | Second header word |
| seq_opptr | input | 5 | Opcode pointer in halfwords |
| op_len_hw | input | LEN_W | Opcode area length in halfwords |
| csr_op | input | 2 | 00 none, 01 read, 10 immediate write, 11 register write |
| csr_sel | input | 1 | 0 live word, 1 saved word |
| csr_imm | input | 5 | Immediate write value |
| csr_wdata | input | 32 | Register write value |
| trap_i | input | 1 | Trap entry strobe |
| ret_i | input | 1 | Trap return strobe |
| csr_rdata | output | 32 | Selected word, full width |
| jump_vld | output | 1 | One-cycle jump request |
| jump_ptr | output | 5 | Target opcode pointer |
| illegal | output | 1 | One-cycle illegal-instruction flag |

## Verification
The two functions that can meet in one cycle are a trap and a software write to the register: a write strobe held in the same cycle as `trap_i`. The bench provokes this with both a legal and an illegal live write. It then checks that no jump or illegal flag appears and that the saved word holds the pre-write live value. A second collision puts a sequencer load in the same cycle as a legal jump write. That case is judged by reading back a live word that carries the old fields and the new pointer.

// File: rtl/subpc_pkg.sv
// Package: shared field widths and the packed layout of the sub-program
// counter word. Assumes a 32-bit CSR word.
package subpc_pkg;
    localparam int XLEN   = 32;
    localparam int PTR_W  = 5;
    localparam int HDR2_W = 16;

    typedef enum logic [1:0] {
        ST_SCALAR = 2'b00,
        ST_HDR    = 2'b01,
        ST_VLDONE = 2'b10,
        ST_TABLES = 2'b11
    } sp_status_e;

    typedef enum logic [1:0] {
        CSR_NONE = 2'b00,
        CSR_RD   = 2'b01,
        CSR_WIMM = 2'b10,
        CSR_WREG = 2'b11
    } csr_op_e;

    typedef struct packed {
        sp_status_e          status;
        logic                vlset;
        logic [2:0]          ilen;
        logic [1:0]          pplen;
        logic [1:0]          rplen;
        logic                mode;
        logic [HDR2_W-1:0]   hdr2;
        logic [PTR_W-1:0]    opptr;
    } sp_word_t;
endpackage

// File: rtl/subpc_wcheck.sv
// Module: write legality check for the live word. Forms the candidate
// pointer (zero-extended immediate or the whole register value) and decides
// whether a jump write is allowed. Purely combinational.
module subpc_wcheck
    import subpc_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  sp_status_e        cur_status,
    input  logic              is_imm,
    input  logic [PTR_W-1:0]  imm,
    input  logic [XLEN-1:0]   wdata,
    input  logic [LEN_W-1:0]  len_hw,
    output logic              legal,
    output logic [PTR_W-1:0]  new_ptr
);
    localparam int PAD_W = XLEN - PTR_W;

    logic [XLEN-1:0] cand;
    logic            in_range;

    // Select the pointer candidate and compare it against the area length
    always_comb begin
        cand     = is_imm ? {{PAD_W{1'b0}}, imm} : wdata;
        in_range = cand < XLEN'(len_hw);
        legal    = (cur_status == ST_TABLES) && in_range;
        new_ptr  = cand[PTR_W-1:0];
    end
endmodule

// File: rtl/subpc_live_reg.sv
// Module: the live sub-program counter word. Priority: restore, then jump
// write, then sequencer load. Assumes the caller already gated the requests.
module subpc_live_reg
    import subpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_restore,
    input  sp_word_t         restore_word,
    input  logic             do_jump,
    input  logic [PTR_W-1:0] jump_to,
    input  logic             do_seq,
    input  sp_word_t         seq_word,
    output sp_word_t         live_q
);
    sp_word_t restored;

    // Lower the status on restore so the tables are read again
    always_comb begin
        restored = restore_word;
        if (restore_word.status == ST_TABLES)
            restored.status = ST_VLDONE;
    end

    // Update the live word by priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            live_q <= '0;
        else if (do_restore)
            live_q <= restored;
        else if (do_jump)
            live_q.opptr <= jump_to;
        else if (do_seq)
            live_q <= seq_word;
    end

    a_r9_restore_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(do_restore) |-> live_q.status != ST_TABLES)
        else $error("R9: restored status still 11");
endmodule

// File: rtl/subpc_save_reg.sv
// Module: the trap-save copy of the word. A trap capture wins over software
// writes, which are never checked. Assumes the caller gated the writes.
module subpc_save_reg
    import subpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_capture,
    input  sp_word_t         live_word,
    input  logic             wr_full,
    input  logic [XLEN-1:0]  wdata,
    input  logic             wr_ptr,
    input  logic [PTR_W-1:0] imm,
    output sp_word_t         saved_q
);
    // Capture on trap, or take an unchecked software write
    always_ff @(posedge clk) begin
        if (!rst_n)
            saved_q <= '0;
        else if (do_capture)
            saved_q <= live_word;
        else if (wr_full)
            saved_q <= sp_word_t'(wdata);
        else if (wr_ptr)
            saved_q.opptr <= imm;
    end

    a_r8_capture_copies: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(do_capture) |-> saved_q == $past(live_word))
        else $error("R8: saved word differs from captured live word");
endmodule

// File: rtl/subpc_csr_ctrl.sv
// Module: top of the sub-program counter CSR controller. Decodes CSR accesses
// and trap/return strobes, drives the live and saved registers, and issues
// one-cycle jump and illegal pulses. Assumes one access per cycle at most.
module subpc_csr_ctrl
    import subpc_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_upd,
    input  logic [1:0]        seq_status,
    input  logic              seq_vlset,
    input  logic [2:0]        seq_ilen,
    input  logic [1:0]        seq_pplen,
    input  logic [1:0]        seq_rplen,
    input  logic              seq_mode,
    input  logic [15:0]       seq_hdr2,
    input  logic [4:0]        seq_opptr,
    input  logic [LEN_W-1:0]  op_len_hw,
    input  logic [1:0]        csr_op,
    input  logic              csr_sel,
    input  logic [4:0]        csr_imm,
    input  logic [31:0]       csr_wdata,
    input  logic              trap_i,
    input  logic              ret_i,
    output logic [31:0]       csr_rdata,
    output logic              jump_vld,
    output logic [4:0]        jump_ptr,
    output logic              illegal
);
    sp_word_t         live_q, saved_q, seq_word;
    logic             is_wr, is_imm, blocked, live_wr, sav_wr;
    logic             wr_legal, do_jump, do_bad, do_restore, do_seq;
    logic [PTR_W-1:0] new_ptr;

    // Pack the sequencer inputs into the word layout
    always_comb begin
        seq_word.status = sp_status_e'(seq_status);
        seq_word.vlset  = seq_vlset;
        seq_word.ilen   = seq_ilen;
        seq_word.pplen  = seq_pplen;
        seq_word.rplen  = seq_rplen;
        seq_word.mode   = seq_mode;
        seq_word.hdr2   = seq_hdr2;
        seq_word.opptr  = seq_opptr;
    end

    // Decode the access and resolve priorities between events
    always_comb begin
        is_wr      = (csr_op == CSR_WIMM) || (csr_op == CSR_WREG);
        is_imm     = (csr_op == CSR_WIMM);
        blocked    = trap_i || ret_i;
        live_wr    = is_wr && !csr_sel && !blocked;
        sav_wr     = is_wr &&  csr_sel && !blocked;
        do_jump    = live_wr && wr_legal;
        do_bad     = live_wr && !wr_legal;
        do_restore = ret_i && !trap_i;
        do_seq     = seq_upd && !blocked && !live_wr;
    end

    subpc_wcheck #(.LEN_W(LEN_W)) chk_i (
        .cur_status (live_q.status),
        .is_imm     (is_imm),
        .imm        (csr_imm),
        .wdata      (csr_wdata),
        .len_hw     (op_len_hw),
        .legal      (wr_legal),
        .new_ptr    (new_ptr)
    );

    subpc_live_reg live_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .do_restore   (do_restore),
        .restore_word (saved_q),
        .do_jump      (do_jump),
        .jump_to      (new_ptr),
        .do_seq       (do_seq),
        .seq_word     (seq_word),
        .live_q       (live_q)
    );

    subpc_save_reg save_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_capture (trap_i),
        .live_word  (live_q),
        .wr_full    (sav_wr && !is_imm),
        .wdata      (csr_wdata),
        .wr_ptr     (sav_wr && is_imm),
        .imm        (csr_imm),
        .saved_q    (saved_q)
    );

    // Register the jump and illegal pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jump_vld <= 1'b0;
            jump_ptr <= '0;
            illegal  <= 1'b0;
        end else begin
            jump_vld <= do_jump || do_restore;
            jump_ptr <= do_restore ? saved_q.opptr : new_ptr;
            illegal  <= do_bad;
        end
    end

    // Return the full selected word
    always_comb csr_rdata = csr_sel ? XLEN'(saved_q) : XLEN'(live_q);

    a_r1_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(jump_vld && illegal))
        else $error("R1: jump and illegal together");
    a_r3_jump_matches_live: assert property (@(posedge clk) disable iff (!rst_n)
        jump_vld |-> live_q.opptr == jump_ptr)
        else $error("R3: jump pointer differs from live pointer");
    a_r4_illegal_keeps_live: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && illegal |-> live_q == $past(live_q))
        else $error("R4: live word changed on illegal write");
    a_r10_trap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(trap_i) |-> !jump_vld && !illegal)
        else $error("R10: pulse after trap cycle");
endmodule

// File: tb/subpc_csr_ctrl_tb_top.sv
module subpc_csr_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        seq_upd;
    logic [1:0]  seq_status;
    logic        seq_vlset;
    logic [2:0]  seq_ilen;
    logic [1:0]  seq_pplen, seq_rplen;
    logic        seq_mode;
    logic [15:0] seq_hdr2;
    logic [4:0]  seq_opptr;
    logic [5:0]  op_len_hw;
    logic [1:0]  csr_op;
    logic        csr_sel;
    logic [4:0]  csr_imm;
    logic [31:0] csr_wdata;
    logic        trap_i, ret_i;
    logic [31:0] csr_rdata;
    logic        jump_vld;
    logic [4:0]  jump_ptr;
    logic        illegal;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    subpc_csr_ctrl #(.LEN_W(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .seq_upd(seq_upd), .seq_status(seq_status),
        .seq_vlset(seq_vlset), .seq_ilen(seq_ilen), .seq_pplen(seq_pplen),
        .seq_rplen(seq_rplen), .seq_mode(seq_mode), .seq_hdr2(seq_hdr2),
        .seq_opptr(seq_opptr), .op_len_hw(op_len_hw), .csr_op(csr_op),
        .csr_sel(csr_sel), .csr_imm(csr_imm), .csr_wdata(csr_wdata),
        .trap_i(trap_i), .ret_i(ret_i), .csr_rdata(csr_rdata),
        .jump_vld(jump_vld), .jump_ptr(jump_ptr), .illegal(illegal)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear();
        seq_upd = 0; csr_op = 2'b00; csr_sel = 0; csr_imm = 0;
        csr_wdata = 0; trap_i = 0; ret_i = 0;
    endtask

    task automatic put_seq(input logic [31:0] w);
        seq_status = w[31:30]; seq_vlset = w[29]; seq_ilen = w[28:26];
        seq_pplen = w[25:24]; seq_rplen = w[23:22]; seq_mode = w[21];
        seq_hdr2 = w[20:5]; seq_opptr = w[4:0];
    endtask

    task automatic load_seq(input logic [31:0] w);
        put_seq(w); seq_upd = 1; tick(); clear();
    endtask

    task automatic access(input logic [1:0] op, input logic sel, input logic [4:0] imm,
                          input logic [31:0] wd, input logic tr, input logic rt);
        csr_op = op; csr_sel = sel; csr_imm = imm; csr_wdata = wd;
        trap_i = tr; ret_i = rt;
        tick(); clear();
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        csr_sel = sel; #1; v = csr_rdata; csr_sel = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, w, p1, p2, e;
        int lens [6] = '{0, 1, 17, 31, 32, 40};
        logic [31:0] rvals [8] = '{32'd0, 32'd19, 32'd20, 32'd31, 32'h23,
                                   32'h8000_0004, 32'd7, 32'h0000_0100};
        clear(); put_seq(32'h0); op_len_hw = 6'd0; rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        rd(0, v); chk("R1 live", v, 0);
        rd(1, v); chk("R1 saved", v, 0);
        chk("R1 jump", {31'b0, jump_vld}, 0);
        chk("R1 illegal", {31'b0, illegal}, 0);

        // R2 read layout and full width
        for (int k = 0; k < 4; k++) begin
            w = {k[1:0], k[0], 3'(k + 2), 2'(3 - k), 2'(k), ~k[0], 16'(16'h1234 * (k + 1)), 5'(k * 7 + 3)};
            load_seq(w);
            csr_op = 2'b01; rd(0, v); csr_op = 2'b00;
            chk("R2 read full word", v, w);
        end

        // R3 R4 R5 immediate write sweep
        for (int st = 0; st < 4; st++)
            for (int li = 0; li < 6; li++)
                for (int im = 0; im < 32; im++) begin
                    logic lg;
                    w = {st[1:0], 1'b1, 3'd5, 2'd2, 2'd1, 1'b0, 16'hA5C3, 5'd9};
                    load_seq(w);
                    op_len_hw = 6'(lens[li]);
                    access(2'b10, 0, 5'(im), 32'h0, 0, 0);
                    lg = (st == 3) && (im < lens[li]);
                    chk(lg ? "R3 jump" : (st != 3 ? "R4 no jump" : "R5 no jump"),
                        {31'b0, jump_vld}, {31'b0, lg});
                    chk(st != 3 ? "R4 illegal" : "R5 illegal", {31'b0, illegal}, {31'b0, !lg});
                    if (lg) chk("R3 jump_ptr", {27'b0, jump_ptr}, im);
                    rd(0, v);
                    e = lg ? {w[31:5], 5'(im)} : w;
                    chk(lg ? "R3 live word" : "R4 R5 live kept", v, e);
                end

        // R6 register-form write, whole value as pointer
        op_len_hw = 6'd20;
        for (int k = 0; k < 8; k++) begin
            logic lg;
            w = {2'b11, 1'b0, 3'd7, 2'd3, 2'd3, 1'b1, 16'h0F0F, 5'd1};
            load_seq(w);
            access(2'b11, 0, 5'd0, rvals[k], 0, 0);
            lg = rvals[k] < 32'd20;
            chk("R6 jump", {31'b0, jump_vld}, {31'b0, lg});
            chk("R6 illegal", {31'b0, illegal}, {31'b0, !lg});
            rd(0, v);
            chk("R6 live word", v, lg ? {w[31:5], rvals[k][4:0]} : w);
        end
        load_seq({2'b10, 25'h0, 5'd3});
        access(2'b11, 0, 5'd0, 32'd1, 0, 0);
        chk("R6 status gate illegal", {31'b0, illegal}, 1);

        // R7 saved copy writes unchecked
        w = {2'b00, 25'h155, 5'd2};
        load_seq(w); op_len_hw = 6'd0;
        access(2'b11, 1, 5'd0, 32'hDEADBEEF, 0, 0);
        chk("R7 no illegal", {31'b0, illegal}, 0);
        chk("R7 no jump", {31'b0, jump_vld}, 0);
        rd(1, v); chk("R7 saved full", v, 32'hDEADBEEF);
        access(2'b10, 1, 5'd31, 32'h0, 0, 0);
        chk("R7 imm no illegal", {31'b0, illegal}, 0);
        rd(1, v); chk("R7 saved ptr", v, {32'hDEADBEEF >> 5, 5'd31});
        rd(0, v); chk("R7 live untouched", v, w);

        // R8 trap capture, R9 return with status lowering
        p1 = {2'b11, 1'b1, 3'd2, 2'd1, 2'd2, 1'b1, 16'hBEEF, 5'd12};
        load_seq(p1);
        access(2'b00, 0, 0, 0, 1, 0);
        rd(1, v); chk("R8 saved copy", v, p1);
        rd(0, v); chk("R8 live kept", v, p1);
        p2 = {2'b01, 25'h0ABC, 5'd4};
        load_seq(p2);
        access(2'b00, 0, 0, 0, 0, 1);
        chk("R9 jump", {31'b0, jump_vld}, 1);
        chk("R9 jump_ptr", {27'b0, jump_ptr}, 12);
        rd(0, v); chk("R9 restored status 10", v, {2'b10, p1[29:0]});
        access(2'b11, 1, 0, p2, 0, 0);
        access(2'b00, 0, 0, 0, 0, 1);
        rd(0, v); chk("R9 status 01 kept", v, p2);
        chk("R9 jump_ptr 2", {27'b0, jump_ptr}, 4);

        // R10 trap collides with a write
        p1 = {2'b11, 25'h1F0F0F, 5'd2};
        load_seq(p1); op_len_hw = 6'd30;
        access(2'b10, 0, 5'd5, 0, 1, 0);
        chk("R10 no jump", {31'b0, jump_vld}, 0);
        chk("R10 no illegal", {31'b0, illegal}, 0);
        rd(1, v); chk("R10 saved pre-write", v, p1);
        rd(0, v); chk("R10 live kept", v, p1);
        load_seq({2'b00, 25'h3, 5'd1});
        access(2'b11, 0, 0, 32'd99, 1, 0);
        chk("R10 illegal suppressed", {31'b0, illegal}, 0);
        access(2'b10, 0, 5'd6, 0, 1, 1);
        chk("R10 return cancelled", {31'b0, jump_vld}, 0);

        // R11 sequencer load versus live write and read
        p1 = {2'b11, 25'h0123, 5'd0};
        load_seq(p1);
        put_seq({2'b00, 25'h1FFFFFF, 5'd30});
        seq_upd = 1;
        access(2'b10, 0, 5'd8, 0, 0, 0);
        rd(0, v); chk("R11 write beats load", v, {p1[31:5], 5'd8});
        put_seq(p2); seq_upd = 1;
        access(2'b01, 0, 0, 0, 0, 0);
        rd(0, v); chk("R11 load with read", v, p2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule